// File: doc/BRIEF.md
# Two-Port-Write Program Register Store

This block holds the eight 32-bit program registers of a sequential processor core. Two selector inputs pick registers for two independent combinational read ports. Two clocked write ports take the ALU result and the memory result. Each port has a 4-bit selector. Codes 0 to 7 name a register. Code 8 means "no register".

The processor uses the two write ports together when one instruction must change two registers. A stack pop is the usual case: the popped value goes to the destination register and the adjusted stack pointer goes to register 4, both on the same clock edge. Stack instructions also read register 4 through both read ports at once.

Top module: `regstore_top`

## Requirements
- R1: Read port A output `rd_a_data` shows the current content of the register named by `rd_a_sel` combinationally, with no clock edge needed.
- R2: Read port B output `rd_b_data` shows the current content of the register named by `rd_b_sel` combinationally, independently of port A.
- R3: A read selector value of 8 or higher gives an output of 0.
- R4: On a rising edge, the execute write port stores `wr_e_data` into the register named by `wr_e_sel` when that selector is 0 to 7.
- R5: On a rising edge, the memory write port stores `wr_m_data` into the register named by `wr_m_sel` when that selector is 0 to 7.
- R6: A write selector of 8 or higher changes no register.
- R7: When both write selectors name the same register on one edge, the memory port value is stored.
- R8: Both ports can write different registers on one edge. For example, selector 4 (the stack pointer) on the execute port and another register on the memory port both update.
- R9: A read in the same cycle as a write to that register returns the old value until the edge. The new value appears after the edge.
- R10: A synchronous active-high `rst` clears all eight registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 4 | Read port A selector |
| rd_b_sel | input | 4 | Read port B selector |
| rd_a_data | output | 32 | Read port A data |
| rd_b_data | output | 32 | Read port B data |
| wr_e_sel | input | 4 | Execute write selector |
| wr_e_data | input | 32 | Execute write data |
| wr_m_sel | input | 4 | Memory write selector |
| wr_m_data | input | 32 | Memory write data |

## Verification
The bench targets the same-register double write. A design with the wrong priority would leave the execute value there instead of the memory value. It checks that selector 8 is ignored on the write ports: a design that decoded only the low three bits would overwrite register 0. It also checks that selector 8 reads as zero: such a design would return register 0's content. It reads a register in the same cycle it is written, to catch a design that bypasses the new value to the read port early. It runs a pop-style cycle that writes register 4 and another register together, to catch a design that drops one of the two writes.

// File: rtl/regstore_pkg.sv
package regstore_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned NUM_REG = 8;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned IDX_W   = $clog2(NUM_REG);
    localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(NUM_REG);
    localparam logic [SEL_W-1:0] SEL_STACK = SEL_W'(4);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        sel_t  sel;
        word_t data;
    } wr_req_t;

    function automatic logic sel_valid(input sel_t s);
        return s < SEL_W'(NUM_REG);
    endfunction

    function automatic logic [IDX_W-1:0] sel_idx(input sel_t s);
        return s[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/regstore_wdec.sv
module regstore_wdec
    import regstore_pkg::*;
(
    input  wr_req_t              req_e,
    input  wr_req_t              req_m,
    output logic [NUM_REG-1:0]   we,
    output word_t                wdata [NUM_REG]
);
    for (genvar g = 0; g < NUM_REG; g++) begin : g_dec
        logic hit_e, hit_m;
        always_comb begin
            hit_e = sel_valid(req_e.sel) && (sel_idx(req_e.sel) == IDX_W'(g));
            hit_m = sel_valid(req_m.sel) && (sel_idx(req_m.sel) == IDX_W'(g));
            we[g] = hit_e | hit_m;
            wdata[g] = hit_m ? req_m.data : req_e.data;
        end
    end
endmodule

// File: rtl/regstore_bank.sv
module regstore_bank
    import regstore_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REG-1:0] we,
    input  word_t              wdata [NUM_REG],
    output word_t              q [NUM_REG]
);
    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)        q[g] <= '0;
            else if (we[g]) q[g] <= wdata[g];
        end
    end
endmodule

// File: rtl/regstore_rport.sv
module regstore_rport
    import regstore_pkg::*;
(
    input  sel_t  sel,
    input  word_t q [NUM_REG],
    output word_t data
);
    always_comb begin
        data = '0;
        if (sel_valid(sel)) data = q[sel_idx(sel)];
    end
endmodule

// File: rtl/regstore_top.sv
module regstore_top
    import regstore_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  rd_a_sel,
    input  logic [3:0]  rd_b_sel,
    output logic [31:0] rd_a_data,
    output logic [31:0] rd_b_data,
    input  logic [3:0]  wr_e_sel,
    input  logic [31:0] wr_e_data,
    input  logic [3:0]  wr_m_sel,
    input  logic [31:0] wr_m_data
);
    wr_req_t            req_e, req_m;
    logic [NUM_REG-1:0] we;
    word_t              wdata [NUM_REG];
    word_t              q     [NUM_REG];

    assign req_e = '{sel: wr_e_sel, data: wr_e_data};
    assign req_m = '{sel: wr_m_sel, data: wr_m_data};

    regstore_wdec  u_wdec (.req_e(req_e), .req_m(req_m), .we(we), .wdata(wdata));
    regstore_bank  u_bank (.clk(clk), .rst(rst), .we(we), .wdata(wdata), .q(q));
    regstore_rport u_rpa  (.sel(rd_a_sel), .q(q), .data(rd_a_data));
    regstore_rport u_rpb  (.sel(rd_b_sel), .q(q), .data(rd_b_data));
endmodule

// File: rtl/regstore_chk.sv
module regstore_chk
    import regstore_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  rd_a_sel,
    input logic [3:0]  rd_b_sel,
    input logic [31:0] rd_a_data,
    input logic [31:0] rd_b_data,
    input logic [3:0]  wr_e_sel,
    input logic [31:0] wr_e_data,
    input logic [3:0]  wr_m_sel,
    input logic [31:0] wr_m_data
);
    logic live;
    always_ff @(posedge clk) live <= !rst;

    always_comb begin
        if (rd_a_sel >= 4'd8) p_none_read_a_r3: assert (rd_a_data == '0);
        if (rd_b_sel >= 4'd8) p_none_read_b_r3: assert (rd_b_data == '0);
        if (rd_a_sel == rd_b_sel) p_same_sel_r1: assert (rd_a_data == rd_b_data);
    end

    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (rd_a_data == '0 && rd_b_data == '0));
    p_e_write_r4: assert property (@(posedge clk) disable iff (rst || !live)
        (wr_e_sel < 4'd8 && wr_m_sel != wr_e_sel && !$isunknown(wr_e_data)) ##1 (!rst && rd_a_sel == $past(wr_e_sel))
        |-> rd_a_data == $past(wr_e_data));
    p_m_write_r5: assert property (@(posedge clk) disable iff (rst || !live)
        (wr_m_sel < 4'd8) ##1 (!rst && rd_b_sel == $past(wr_m_sel))
        |-> rd_b_data == $past(wr_m_data));
    p_no_write_r6: assert property (@(posedge clk) disable iff (rst || !live)
        (wr_e_sel >= 4'd8 && wr_m_sel >= 4'd8) ##1 (!rst && rd_a_sel == $past(rd_a_sel))
        |-> rd_a_data == $past(rd_a_data));
endmodule

bind regstore_top regstore_chk u_chk (.*);

// File: tb/test_regstore_top.sv
module test_regstore_top;
    localparam int CLK_PERIOD = 10;
    logic clk = 0, rst = 1;
    logic [3:0]  rd_a_sel = 0, rd_b_sel = 0, wr_e_sel = 8, wr_m_sel = 8;
    logic [31:0] wr_e_data = 0, wr_m_data = 0, rd_a_data, rd_b_data;
    logic [31:0] model [8];
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regstore_top i_regstore_top (.*);

    function automatic logic [31:0] exp_rd(input logic [3:0] s);
        return (s < 8) ? model[s[2:0]] : 32'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] es, input logic [31:0] ed,
                        input logic [3:0] ms, input logic [31:0] md);
        wr_e_sel = es; wr_e_data = ed; wr_m_sel = ms; wr_m_data = md;
        @(posedge clk);
        if (ms < 8) model[ms[2:0]] = md;
        if (es < 8 && es != ms) model[es[2:0]] = ed;
        #1;
        wr_e_sel = 8; wr_m_sel = 8;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 9; i++) begin
            rd_a_sel = 4'(i); rd_b_sel = 4'(8 - i); #1;
            check(req, rd_a_data, exp_rd(rd_a_sel));
            check(req, rd_b_data, exp_rd(rd_b_sel));
        end
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        fails++; checks++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) model[i] = 0;
        // fill registers with junk, then reset
        rst = 0;
        for (int i = 0; i < 8; i++) step(4'(i), 32'hDEAD0000 + 32'(i), 8, 0);
        rst = 1; @(posedge clk); #1; rst = 0;
        for (int i = 0; i < 8; i++) model[i] = 0;
        read_all("R10");
        // R4 / R5 basic writes
        step(1, 32'h11111111, 8, 0);
        step(8, 0, 2, 32'h22222222);
        rd_a_sel = 1; rd_b_sel = 2; #1;
        check("R4", rd_a_data, 32'h11111111);
        check("R5", rd_b_data, 32'h22222222);
        // R7 collision
        step(3, 32'hEEEEEEEE, 3, 32'h33333333);
        rd_a_sel = 3; #1; check("R7", rd_a_data, 32'h33333333);
        // R8 pop-style dual write: sp on E, reg 0 on M
        step(4, 32'h00000104, 0, 32'hCAFEF00D);
        rd_a_sel = 4; rd_b_sel = 4; #1;
        check("R8", rd_a_data, 32'h00000104);
        check("R8", rd_b_data, 32'h00000104);
        rd_a_sel = 0; #1; check("R8", rd_a_data, 32'hCAFEF00D);
        // R6: selector 8 and above ignored
        step(8, 32'hBAD0BAD0, 15, 32'hBAD1BAD1);
        read_all("R6");
        // R3: read selectors above 8
        rd_a_sel = 9; rd_b_sel = 15; #1;
        check("R3", rd_a_data, 0); check("R3", rd_b_data, 0);
        // R9: read during write shows old value
        @(negedge clk);
        rd_a_sel = 5; wr_e_sel = 5; wr_e_data = 32'h55555555; wr_m_sel = 8; #1;
        check("R9", rd_a_data, model[5]);
        @(posedge clk); model[5] = 32'h55555555; #1;
        wr_e_sel = 8;
        check("R9", rd_a_data, 32'h55555555);
        // R1 / R2 combinational follow
        for (int i = 0; i < 8; i++) begin
            rd_a_sel = 4'(i); rd_b_sel = 4'(7 - i); #1;
            check("R1", rd_a_data, model[i]);
            check("R2", rd_b_data, model[7 - i]);
        end
        // random mix
        for (int n = 0; n < 400; n++) begin
            step(4'($urandom_range(0, 9)), $urandom, 4'($urandom_range(0, 9)), $urandom);
            rd_a_sel = 4'($urandom_range(0, 9)); rd_b_sel = 4'($urandom_range(0, 9)); #1;
            check("R1", rd_a_data, exp_rd(rd_a_sel));
            check("R2", rd_b_data, exp_rd(rd_b_sel));
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule